// File: doc/BRIEF.md
# Load-Use Stall and Delay-Slot Controller

This block sits beside a five-stage integer pipeline and decides, every cycle, whether the front end must pause. It looks at two instruction latches. The execute latch (the instruction about to compute) and the memory latch (the instruction one step further on) are each described by an instruction class and their register fields. When the memory latch holds a load whose destination is needed by the execute instruction before the loaded word exists, the controller raises a stall. During that stall, fetch, decode and execute stay frozen and the memory latch is emptied, while memory access and writeback carry on. On the cycle after a stall it asks the datapath to keep the load data register unchanged, so the stalled instruction can still pick up the word.

A store that only needs the loaded word as the data it writes does not stall. Instead, the controller flags that the load result should be forwarded to the memory write port. The block also watches the fetch stream for control transfers. After a jump or branch, the next two accepted fetches must be empty slots. Any other instruction in those slots is reported as a violation.

Top module: `ld_hazard_ctl`

## Requirements
- R1: Class encoding is 0 empty, 1 ALU, 2 load, 3 store, 4 jump, 5 branch, and codes 6 and 7 act as empty. With a load in the memory latch whose destination `mem_rd` is nonzero, an ALU instruction in execute stalls if `ex_rs1` equals `mem_rd`. In register form (`ex_imm`=0) it also stalls if `ex_rs2` equals `mem_rd`. In immediate form (`ex_imm`=1), `ex_rs2` is ignored.
- R2: With a nonzero-destination load in the memory latch, a load or store in execute stalls when its address register `ex_rs1` equals `mem_rd`.
- R3: A store in execute whose data register `ex_rs2` equals a nonzero load destination `mem_rd` raises `st_fwd` in the same cycle. This match alone never stalls.
- R4: A load with destination register 0 never causes a stall or `st_fwd`.
- R5: `if_en`, `id_en` and `ex_en` are each the inverse of `stall`. No stall arises when the memory latch is not a load, or when execute holds an empty, jump or branch slot.
- R6: `mem_kill` is high exactly when `stall` is high.
- R7: `lmdr_hold` is high in the cycle that follows a cycle with `stall` high, and low otherwise.
- R8: After a jump or branch is accepted by fetch, the next two accepted fetches must be class empty. Each non-empty one raises `slot_err` for one cycle after the edge that accepted it.
- R9: A fetch cycle with `stall` high is not accepted, and does not use up a slot or raise `slot_err`.
- R10: After reset, `lmdr_hold` and `slot_err` are low and no delay-slot window is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_cls | input | 3 | Class of the instruction being fetched |
| ex_cls | input | 3 | Class of the execute-latch instruction |
| ex_imm | input | 1 | Execute ALU instruction uses an immediate for its second operand |
| ex_rs1 | input | REG_W | First (address) operand register of execute instruction |
| ex_rs2 | input | REG_W | Second (data) operand register of execute instruction |
| mem_cls | input | 3 | Class of the memory-latch instruction |
| mem_rd | input | REG_W | Destination register of the memory-latch instruction |
| stall | output | 1 | Load-use hazard: front end frozen this cycle |
| mem_kill | output | 1 | Replace the memory latch with an empty slot |
| if_en | output | 1 | Fetch stage update enable |
| id_en | output | 1 | Decode stage update enable |
| ex_en | output | 1 | Execute stage update enable |
| lmdr_hold | output | 1 | Keep the load data register unchanged |
| st_fwd | output | 1 | Route load result to the store write port |
| slot_err | output | 1 | Delay-slot violation detected |

## Verification
The hazard decision is combinational, so a wrong comparison or class decode shows on `stall`, `mem_kill` and the enables in the same cycle as the offending latch contents. A sweep over every class pair and register triple of a two-bit register file finds such faults at once. The two pieces of state fail differently. A stuck or mistimed hold register shows one cycle after a stall. A miscounted slot window only appears two or three accepted fetches after a jump, or when a stall lands inside the window.

// File: rtl/ld_hazard_pkg.sv
package ld_hazard_pkg;
  typedef enum logic [2:0] {
    CLS_NONE   = 3'd0,
    CLS_ALU    = 3'd1,
    CLS_LOAD   = 3'd2,
    CLS_STORE  = 3'd3,
    CLS_JUMP   = 3'd4,
    CLS_BRANCH = 3'd5
  } ins_cls_e;

  function automatic logic is_mem(input logic [2:0] c);
    return (c == CLS_LOAD) || (c == CLS_STORE);
  endfunction

  function automatic logic is_xfer(input logic [2:0] c);
    return (c == CLS_JUMP) || (c == CLS_BRANCH);
  endfunction
endpackage

// File: rtl/ld_hazard_detect.sv
module ld_hazard_detect
  import ld_hazard_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic [2:0]       ex_cls,
  input  logic             ex_imm,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [2:0]       mem_cls,
  input  logic [REG_W-1:0] mem_rd,
  output logic             risk,
  output logic             st_fwd
);
  logic ld_live;
  logic hit_a;
  logic hit_b;

  always_comb begin
    ld_live = (mem_cls == CLS_LOAD) && (mem_rd != '0);
    hit_a   = (ex_rs1 == mem_rd);
    hit_b   = (ex_rs2 == mem_rd);
    risk    = 1'b0;
    st_fwd  = 1'b0;
    if (ld_live) begin
      if (ex_cls == CLS_ALU)
        risk = hit_a || (!ex_imm && hit_b);
      else if (is_mem(ex_cls))
        risk = hit_a;
      st_fwd = (ex_cls == CLS_STORE) && hit_b;
    end
  end
endmodule

// File: rtl/ld_slot_check.sv
module ld_slot_check
  import ld_hazard_pkg::*;
#(
  parameter int SLOT_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       adv,
  input  logic [2:0] fetch_cls,
  output logic       slot_err
);
  localparam int CW = $clog2(SLOT_N + 1);

  logic [CW-1:0] left_q, left_d;
  logic          err_q, err_d;
  logic          occupied;

  always_comb begin
    left_d   = left_q;
    err_d    = 1'b0;
    occupied = (fetch_cls == CLS_ALU) || (fetch_cls == CLS_LOAD) ||
               (fetch_cls == CLS_STORE) || is_xfer(fetch_cls);
    if (adv) begin
      if (left_q != '0) begin
        err_d  = occupied;
        left_d = left_q - 1'b1;
      end else if (is_xfer(fetch_cls)) begin
        left_d = CW'(SLOT_N);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      err_q  <= 1'b0;
    end else begin
      left_q <= left_d;
      err_q  <= err_d;
    end
  end

  assign slot_err = err_q;
endmodule

// File: rtl/ld_hazard_ctl.sv
module ld_hazard_ctl
  import ld_hazard_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int SLOT_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       fetch_cls,
  input  logic [2:0]       ex_cls,
  input  logic             ex_imm,
  input  logic [REG_W-1:0] ex_rs1,
  input  logic [REG_W-1:0] ex_rs2,
  input  logic [2:0]       mem_cls,
  input  logic [REG_W-1:0] mem_rd,
  output logic             stall,
  output logic             mem_kill,
  output logic             if_en,
  output logic             id_en,
  output logic             ex_en,
  output logic             lmdr_hold,
  output logic             st_fwd,
  output logic             slot_err
);
  logic risk;
  logic hold_q, hold_d;

  ld_hazard_detect #(.REG_W(REG_W)) u_detect (
    .ex_cls  (ex_cls),
    .ex_imm  (ex_imm),
    .ex_rs1  (ex_rs1),
    .ex_rs2  (ex_rs2),
    .mem_cls (mem_cls),
    .mem_rd  (mem_rd),
    .risk    (risk),
    .st_fwd  (st_fwd)
  );

  ld_slot_check #(.SLOT_N(SLOT_N)) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (!risk),
    .fetch_cls (fetch_cls),
    .slot_err  (slot_err)
  );

  always_comb hold_d = risk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_d;
  end

  assign stall     = risk;
  assign mem_kill  = risk;
  assign if_en     = !risk;
  assign id_en     = !risk;
  assign ex_en     = !risk;
  assign lmdr_hold = hold_q;
endmodule

// File: rtl/ld_hazard_chk.sv
module ld_hazard_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       fetch_cls,
  input logic [2:0]       ex_cls,
  input logic [REG_W-1:0] ex_rs1,
  input logic [REG_W-1:0] ex_rs2,
  input logic [2:0]       mem_cls,
  input logic [REG_W-1:0] mem_rd,
  input logic             stall,
  input logic             mem_kill,
  input logic             lmdr_hold,
  input logic             st_fwd,
  input logic             slot_err
);
  assert_stall_needs_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (mem_cls == 3'd2));

  assert_mem_addr_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (ex_cls == 3'd2 || ex_cls == 3'd3)) |-> (ex_rs1 == mem_rd));

  assert_fwd_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_fwd |-> (ex_cls == 3'd3 && ex_rs2 == mem_rd));

  assert_zero_dest_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd == '0) |-> (!stall && !st_fwd));

  assert_kill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> mem_kill);

  assert_hold_after_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> lmdr_hold);

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> !lmdr_hold);

  assert_slot_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall || fetch_cls == 3'd0) |=> !slot_err);
endmodule

bind ld_hazard_ctl ld_hazard_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fetch_cls (fetch_cls),
  .ex_cls    (ex_cls),
  .ex_rs1    (ex_rs1),
  .ex_rs2    (ex_rs2),
  .mem_cls   (mem_cls),
  .mem_rd    (mem_rd),
  .stall     (stall),
  .mem_kill  (mem_kill),
  .lmdr_hold (lmdr_hold),
  .st_fwd    (st_fwd),
  .slot_err  (slot_err)
);

// File: tb/test_ld_hazard_ctl.sv
module test_ld_hazard_ctl;
  localparam int RW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [2:0]    fetch_cls, ex_cls, mem_cls;
  logic          ex_imm;
  logic [RW-1:0] ex_rs1, ex_rs2, mem_rd;
  logic stall, mem_kill, if_en, id_en, ex_en, lmdr_hold, st_fwd, slot_err;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ld_hazard_ctl #(.REG_W(RW), .SLOT_N(2)) i_ld_hazard_ctl (
    .clk(clk), .rst_n(rst_n), .fetch_cls(fetch_cls), .ex_cls(ex_cls),
    .ex_imm(ex_imm), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .mem_cls(mem_cls),
    .mem_rd(mem_rd), .stall(stall), .mem_kill(mem_kill), .if_en(if_en),
    .id_en(id_en), .ex_en(ex_en), .lmdr_hold(lmdr_hold), .st_fwd(st_fwd),
    .slot_err(slot_err)
  );

  task automatic chk(input logic got, input logic exp, input string tag);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0b expected %0b (ex=%0d imm=%0b rs1=%0d rs2=%0d mem=%0d rd=%0d fetch=%0d)",
               tag, got, exp, ex_cls, ex_imm, ex_rs1, ex_rs2, mem_cls, mem_rd, fetch_cls);
    end
  endtask

  // fetch one instruction class; slot_err is checked after the accepting edge
  task automatic fetch_one(input logic [2:0] c, input logic exp_err, input string tag);
    @(negedge clk);
    fetch_cls = c;
    @(posedge clk);
    #5;
    chk(slot_err, exp_err, tag);
  endtask

  task automatic quiet_ex();
    ex_cls = 3'd0; ex_imm = 1'b0; ex_rs1 = '0; ex_rs2 = '0;
    mem_cls = 3'd0; mem_rd = '0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic prev_st;
    rst_n = 1'b0;
    fetch_cls = 3'd0;
    quiet_ex();
    #35;
    // R10: reset state
    chk(lmdr_hold, 1'b0, "R10 lmdr_hold in reset");
    chk(slot_err, 1'b0, "R10 slot_err in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #5;
    chk(lmdr_hold, 1'b0, "R10 lmdr_hold after reset");
    chk(slot_err, 1'b0, "R10 slot_err after reset");
    // R10: a first non-empty fetch opens no window
    fetch_one(3'd1, 1'b0, "R10 no window after reset");

    // exhaustive sweep of hazard logic over RW=2 register file
    prev_st = 1'b0;
    for (int ec = 0; ec < 8; ec++)
      for (int mc = 0; mc < 6; mc++)
        for (int im = 0; im < 2; im++)
          for (int rd = 0; rd < 4; rd++)
            for (int a = 0; a < 4; a++)
              for (int b = 0; b < 4; b++) begin
                logic exp_st, exp_fw, ld;
                string tg;
                @(negedge clk);
                chk(lmdr_hold, prev_st, "R7 lmdr_hold follows stall");
                ex_cls = 3'(ec); mem_cls = 3'(mc); ex_imm = im[0];
                mem_rd = RW'(rd); ex_rs1 = RW'(a); ex_rs2 = RW'(b);
                fetch_cls = 3'd0;
                ld = (mc == 2) && (rd != 0);
                exp_st = ld && (((ec == 1) && ((a == rd) || (im == 0 && b == rd))) ||
                                ((ec == 2 || ec == 3) && a == rd));
                exp_fw = ld && (ec == 3) && (b == rd);
                #5;
                tg = (ec == 1) ? "R1 stall alu" :
                     (ec == 2 || ec == 3) ? "R2 stall mem" : "R5 no stall";
                chk(stall, exp_st, tg);
                if (rd == 0) chk(stall, 1'b0, "R4 zero dest stall");
                if (rd == 0) chk(st_fwd, 1'b0, "R4 zero dest fwd");
                chk(st_fwd, exp_fw, "R3 store fwd");
                if (ec == 3 && a != b && b == rd) chk(stall, 1'b0, "R3 data-only no stall");
                chk(mem_kill, exp_st, "R6 mem_kill");
                chk(if_en, !exp_st, "R5 if_en");
                chk(id_en, !exp_st, "R5 id_en");
                chk(ex_en, !exp_st, "R5 ex_en");
                prev_st = exp_st;
              end
    @(negedge clk);
    chk(lmdr_hold, prev_st, "R7 lmdr_hold last");
    quiet_ex();
    @(posedge clk); #5;
    chk(lmdr_hold, 1'b0, "R7 lmdr_hold drops");

    // R8: legal jump with two empty slots
    fetch_one(3'd4, 1'b0, "R8 jump");
    fetch_one(3'd0, 1'b0, "R8 slot1 empty");
    fetch_one(3'd0, 1'b0, "R8 slot2 empty");
    fetch_one(3'd1, 1'b0, "R8 after window");
    // R8: branch followed by ALU in first slot
    fetch_one(3'd5, 1'b0, "R8 branch");
    fetch_one(3'd1, 1'b1, "R8 slot1 occupied");
    fetch_one(3'd0, 1'b0, "R8 slot2 empty");
    fetch_one(3'd2, 1'b0, "R8 closed");
    // R8: violation in second slot
    fetch_one(3'd4, 1'b0, "R8 jump");
    fetch_one(3'd0, 1'b0, "R8 slot1 empty");
    fetch_one(3'd3, 1'b1, "R8 slot2 occupied");
    fetch_one(3'd7, 1'b0, "R8 code7 empty");
    // R9: stalled fetch inside window does not consume a slot
    fetch_one(3'd4, 1'b0, "R9 jump");
    @(negedge clk);
    ex_cls = 3'd1; ex_rs1 = 2'd1; mem_cls = 3'd2; mem_rd = 2'd1;
    fetch_cls = 3'd1;
    @(posedge clk); #5;
    chk(slot_err, 1'b0, "R9 stalled fetch ignored");
    @(negedge clk);
    quiet_ex();
    fetch_cls = 3'd0;
    @(posedge clk); #5;
    chk(slot_err, 1'b0, "R9 slot1 empty");
    fetch_one(3'd1, 1'b1, "R9 slot2 still counted");
    fetch_one(3'd1, 1'b0, "R9 window closed");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule